// File: doc/BRIEF.md
# Dual-Channel Serial Port Host Register Front End

This block is the host-side register file for a two-channel serial port. A CPU drives one shared 3-bit address, an 8-bit write bus, a channel-select bit and single-cycle read and write strobes. The block decodes each access into one of two per-channel register sets, A and B. It returns read data on a registered read bus. It drives each channel's active-low multifunction pin. It also exports the programmed transmit and receive trigger levels.

A chip-wide alternate function register, shared by both channels, controls two features. The first is a concurrent-write mode, in which a single bus write lands in the addressed register of both channels. The second is a pin-function selector for the multifunction outputs. Several registers are reachable only under specific conditions. The divisor latches and the alternate function register need the divisor-access bit (LCR bit 7). The trigger-level and FIFO-count register needs the enhanced-access line control value 0xBF. The identification and revision values appear only while both divisor latches are zero. The shift engines, baud generator and FIFO storage are outside this block; their FIFO counts, baud clock, receive-ready flag and OP2 bit arrive as input ports.

Top module: `duart_regfront`

## Requirements
- R1: After reset, every register is 0, `busRdata` is 0x00, all trigger outputs are 0x00, and each `mfPinN` bit equals the inverse of its channel's `op2Bit`.
- R2: While alternate function bit 0 is 0, a write reaches only the channel selected by `chanSel` (0 = A, 1 = B). The other channel reads back unchanged.
- R3: While alternate function bit 0 is 1, a write updates the addressed register in both channels. Each channel applies its own LCR bit 7 to decode addresses 0 to 2.
- R4: A read captures the register of the `chanSel` channel, even in concurrent mode. The value appears on `busRdata` in the cycle after `rdStrobe`, shows the state from before any write in that same cycle, and holds until the next read.
- R5: With the channel's LCR bit 7 set, address 2 is the shared alternate function register, writable and readable from either channel. Bits 7:3 read as 0.
- R6: Each `mfPinN` bit is chosen by alternate function bits 2:1: 00 gives ~`op2Bit`, 01 gives ~`baudClk`, 11 gives ~`rxReady`, and 10 drives 1.
- R7: With LCR bit 7 set, address 0 is the divisor low latch and address 1 the divisor high latch. While both latches hold 0x00, reads of address 0 return 0x0A and reads of address 1 return 0x01.
- R8: Address 5 takes trigger writes only while that channel's LCR equals 0xBF. FCTR (address 4) bit 7 = 0 routes the write to the RX trigger and 1 routes it to the TX trigger. Writes to address 5 have no effect under any other LCR value.
- R9: With LCR = 0xBF, reading address 5 returns the RX FIFO count when FCTR bit 7 is 0 and the TX count when it is 1, zero-extended. Under any other LCR value it reads 0x00.
- R10: When FCTR bit 6 is 1, reading address 7 returns the FIFO count chosen by FCTR bit 7 instead of the scratch register.
- R11: With LCR bit 7 clear, addresses 0, 1 and 2 are the data holding, interrupt-enable and FIFO control registers. Address 3 is LCR, address 4 is FCTR and address 7 is scratch, all read/write. Address 6 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| chanSel | input | 1 | Channel select, 0 = A, 1 = B |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| wrStrobe | input | 1 | Single-cycle write strobe |
| rdStrobe | input | 1 | Single-cycle read strobe |
| busRdata | output | 8 | Registered read data |
| rxCountA | input | CNT_W | Channel A RX FIFO fill count |
| txCountA | input | CNT_W | Channel A TX FIFO fill count |
| rxCountB | input | CNT_W | Channel B RX FIFO fill count |
| txCountB | input | CNT_W | Channel B TX FIFO fill count |
| op2Bit | input | 2 | OP2 level per channel (bit 0 = A) |
| baudClk | input | 2 | Baud clock per channel |
| rxReady | input | 2 | RX-ready flag per channel |
| mfPinN | output | 2 | Active-low multifunction pins |
| rxTrigA | output | 8 | Channel A programmed RX trigger level |
| txTrigA | output | 8 | Channel A programmed TX trigger level |
| rxTrigB | output | 8 | Channel B programmed RX trigger level |
| txTrigB | output | 8 | Channel B programmed TX trigger level |

## Verification
A read and a write can share one cycle. This matters most when concurrent mode is on and the write also lands in the channel being read. The bench provokes this by raising both strobes together, both in directed cases (a scratch write with a same-cycle scratch read) and throughout the random phase. It judges the captured byte against a model value taken before that cycle's write is applied. Then it reads again to confirm that the write took effect in both channels.

// File: rtl/duart_pkg.sv
package duart_pkg;
  localparam int REG_W = 8;
  localparam int ADDR_W = 3;
  localparam int NUM_CH = 2;
  localparam int AFR_W = 3;
  localparam int DLAB_BIT = 7;
  localparam int CNT_SEL_BIT = 7;
  localparam int SWAP_BIT = 6;
  localparam logic [REG_W-1:0] DEV_ID = 8'h0A;
  localparam logic [REG_W-1:0] DEV_REV = 8'h01;
  localparam logic [REG_W-1:0] LCR_ENH = 8'hBF;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 3'd0, A_IER = 3'd1, A_FIFO = 3'd2, A_LCR = 3'd3,
    A_FCTR = 3'd4, A_TRG = 3'd5, A_SPARE = 3'd6, A_SCR = 3'd7
  } regAddr_t;

  typedef enum logic [3:0] {
    RD_ZERO, RD_DATA, RD_IER, RD_FIFO, RD_LCR, RD_FCTR, RD_DLL,
    RD_DLM, RD_ID, RD_REV, RD_AFR, RD_COUNT, RD_SCR
  } rdSel_t;

  typedef struct packed {
    logic data;
    logic ier;
    logic fifo;
    logic lcr;
    logic fctr;
    logic dll;
    logic dlm;
    logic scr;
    logic trgRx;
    logic trgTx;
  } chanWr_t;

  typedef struct packed {
    logic [REG_W-1:0] lcr;
    logic dlZero;
    logic cntTx;
    logic cntSwap;
  } chanStat_t;
endpackage

// File: rtl/duart_ctrl.sv
module duart_ctrl
  import duart_pkg::*;
(
  input  logic                      wrStrobe,
  input  logic                      rdStrobe,
  input  logic                      chanSel,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic                      concWr,
  input  chanStat_t [NUM_CH-1:0]    stat,
  output chanWr_t   [NUM_CH-1:0]    wrCmd,
  output logic                      afrWr,
  output logic                      rdEn,
  output logic                      rdChan,
  output rdSel_t                    rdSel
);
  regAddr_t addr;
  logic [NUM_CH-1:0] afrHit;

  assign addr = regAddr_t'(busAddr);

  // Per-channel write decode; each channel applies its own line control state
  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    logic dlab;
    logic enh;
    logic hit;
    logic afrLoc;
    chanWr_t cmd;

    assign dlab = stat[c].lcr[DLAB_BIT];
    assign enh  = (stat[c].lcr == LCR_ENH);
    assign hit  = wrStrobe && (concWr || (chanSel == 1'(c)));

    always_comb begin
      cmd = '0;
      afrLoc = 1'b0;
      if (hit) begin
        case (addr)
          A_DATA:  if (dlab) cmd.dll = 1'b1; else cmd.data = 1'b1;
          A_IER:   if (dlab) cmd.dlm = 1'b1; else cmd.ier = 1'b1;
          A_FIFO:  if (dlab) afrLoc = 1'b1; else cmd.fifo = 1'b1;
          A_LCR:   cmd.lcr = 1'b1;
          A_FCTR:  cmd.fctr = 1'b1;
          A_TRG: begin
            if (enh) begin
              if (stat[c].cntTx) cmd.trgTx = 1'b1;
              else cmd.trgRx = 1'b1;
            end
          end
          A_SCR:   cmd.scr = 1'b1;
          default: ;
        endcase
      end
    end

    assign wrCmd[c]  = cmd;
    assign afrHit[c] = afrLoc;
  end

  assign afrWr  = |afrHit;
  assign rdEn   = rdStrobe;
  assign rdChan = chanSel;

  // Read decode always follows the selected channel
  logic rdDlab;
  logic rdEnh;
  logic rdZero;
  logic rdSwap;
  assign rdDlab = stat[chanSel].lcr[DLAB_BIT];
  assign rdEnh  = (stat[chanSel].lcr == LCR_ENH);
  assign rdZero = stat[chanSel].dlZero;
  assign rdSwap = stat[chanSel].cntSwap;

  always_comb begin
    rdSel = RD_ZERO;
    case (addr)
      A_DATA: begin
        if (!rdDlab) rdSel = RD_DATA;
        else if (rdZero) rdSel = RD_ID;
        else rdSel = RD_DLL;
      end
      A_IER: begin
        if (!rdDlab) rdSel = RD_IER;
        else if (rdZero) rdSel = RD_REV;
        else rdSel = RD_DLM;
      end
      A_FIFO:  rdSel = rdDlab ? RD_AFR : RD_FIFO;
      A_LCR:   rdSel = RD_LCR;
      A_FCTR:  rdSel = RD_FCTR;
      A_TRG:   rdSel = rdEnh ? RD_COUNT : RD_ZERO;
      A_SPARE: rdSel = RD_ZERO;
      A_SCR:   rdSel = rdSwap ? RD_COUNT : RD_SCR;
      default: rdSel = RD_ZERO;
    endcase
  end
endmodule

// File: rtl/duart_chanregs.sv
module duart_chanregs
  import duart_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  chanWr_t          wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] datQ,
  output logic [REG_W-1:0] ierQ,
  output logic [REG_W-1:0] fifoQ,
  output logic [REG_W-1:0] lcrQ,
  output logic [REG_W-1:0] fctrQ,
  output logic [REG_W-1:0] dllQ,
  output logic [REG_W-1:0] dlmQ,
  output logic [REG_W-1:0] scrQ,
  output logic [REG_W-1:0] rxTrgQ,
  output logic [REG_W-1:0] txTrgQ
);
  always_ff @(posedge clk) begin
    if (rst) begin
      datQ   <= '0;
      ierQ   <= '0;
      fifoQ  <= '0;
      lcrQ   <= '0;
      fctrQ  <= '0;
      dllQ   <= '0;
      dlmQ   <= '0;
      scrQ   <= '0;
      rxTrgQ <= '0;
      txTrgQ <= '0;
    end else begin
      if (wr.data)  datQ   <= wdata;
      if (wr.ier)   ierQ   <= wdata;
      if (wr.fifo)  fifoQ  <= wdata;
      if (wr.lcr)   lcrQ   <= wdata;
      if (wr.fctr)  fctrQ  <= wdata;
      if (wr.dll)   dllQ   <= wdata;
      if (wr.dlm)   dlmQ   <= wdata;
      if (wr.scr)   scrQ   <= wdata;
      if (wr.trgRx) rxTrgQ <= wdata;
      if (wr.trgTx) txTrgQ <= wdata;
    end
  end
endmodule

// File: rtl/duart_dpath.sv
module duart_dpath
  import duart_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic                             clk,
  input  logic                             rst,
  input  chanWr_t [NUM_CH-1:0]             wrCmd,
  input  logic                             afrWr,
  input  logic [REG_W-1:0]                 wdata,
  input  logic                             rdEn,
  input  logic                             rdChan,
  input  rdSel_t                           rdSel,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     rxCnt,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     txCnt,
  input  logic [NUM_CH-1:0]                op2Bit,
  input  logic [NUM_CH-1:0]                baudClk,
  input  logic [NUM_CH-1:0]                rxReady,
  output chanStat_t [NUM_CH-1:0]           stat,
  output logic [AFR_W-1:0]                 afrQ,
  output logic [NUM_CH-1:0]                mfPinN,
  output logic [NUM_CH-1:0][REG_W-1:0]     rxTrig,
  output logic [NUM_CH-1:0][REG_W-1:0]     txTrig,
  output logic [REG_W-1:0]                 rdata
);
  localparam int PAD_W = REG_W - CNT_W;
  localparam int AFR_PAD = REG_W - AFR_W;

  logic [NUM_CH-1:0][REG_W-1:0] datR, ierR, fifoR, lcrR, fctrR, dllR, dlmR, scrR;
  logic [NUM_CH-1:0][REG_W-1:0] cntSel;
  logic [REG_W-1:0] rdNext;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    duart_chanregs u_regs (
      .clk    (clk),
      .rst    (rst),
      .wr     (wrCmd[c]),
      .wdata  (wdata),
      .datQ   (datR[c]),
      .ierQ   (ierR[c]),
      .fifoQ  (fifoR[c]),
      .lcrQ   (lcrR[c]),
      .fctrQ  (fctrR[c]),
      .dllQ   (dllR[c]),
      .dlmQ   (dlmR[c]),
      .scrQ   (scrR[c]),
      .rxTrgQ (rxTrig[c]),
      .txTrgQ (txTrig[c])
    );

    assign stat[c] = {lcrR[c], (dllR[c] == '0) && (dlmR[c] == '0),
                      fctrR[c][CNT_SEL_BIT], fctrR[c][SWAP_BIT]};

    assign cntSel[c] = fctrR[c][CNT_SEL_BIT] ? {{PAD_W{1'b0}}, txCnt[c]}
                                             : {{PAD_W{1'b0}}, rxCnt[c]};

    // Active-low pin function select, shared selector for both channels
    always_comb begin
      case (afrQ[2:1])
        2'b00:   mfPinN[c] = ~op2Bit[c];
        2'b01:   mfPinN[c] = ~baudClk[c];
        2'b11:   mfPinN[c] = ~rxReady[c];
        default: mfPinN[c] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) afrQ <= '0;
    else if (afrWr) afrQ <= wdata[AFR_W-1:0];
  end

  always_comb begin
    case (rdSel)
      RD_DATA:  rdNext = datR[rdChan];
      RD_IER:   rdNext = ierR[rdChan];
      RD_FIFO:  rdNext = fifoR[rdChan];
      RD_LCR:   rdNext = lcrR[rdChan];
      RD_FCTR:  rdNext = fctrR[rdChan];
      RD_DLL:   rdNext = dllR[rdChan];
      RD_DLM:   rdNext = dlmR[rdChan];
      RD_ID:    rdNext = DEV_ID;
      RD_REV:   rdNext = DEV_REV;
      RD_AFR:   rdNext = {{AFR_PAD{1'b0}}, afrQ};
      RD_COUNT: rdNext = cntSel[rdChan];
      RD_SCR:   rdNext = scrR[rdChan];
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rdEn) rdata <= rdNext;
  end
endmodule

// File: rtl/duart_regfront.sv
module duart_regfront
  import duart_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 chanSel,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [REG_W-1:0]     busWdata,
  input  logic                 wrStrobe,
  input  logic                 rdStrobe,
  output logic [REG_W-1:0]     busRdata,
  input  logic [CNT_W-1:0]     rxCountA,
  input  logic [CNT_W-1:0]     txCountA,
  input  logic [CNT_W-1:0]     rxCountB,
  input  logic [CNT_W-1:0]     txCountB,
  input  logic [NUM_CH-1:0]    op2Bit,
  input  logic [NUM_CH-1:0]    baudClk,
  input  logic [NUM_CH-1:0]    rxReady,
  output logic [NUM_CH-1:0]    mfPinN,
  output logic [REG_W-1:0]     rxTrigA,
  output logic [REG_W-1:0]     txTrigA,
  output logic [REG_W-1:0]     rxTrigB,
  output logic [REG_W-1:0]     txTrigB
);
  chanStat_t [NUM_CH-1:0] chanStat;
  chanWr_t   [NUM_CH-1:0] wrCmd;
  logic [AFR_W-1:0] afrQ;
  logic afrWr, rdEn, rdChan;
  rdSel_t rdSel;
  logic [NUM_CH-1:0][REG_W-1:0] rxTrig, txTrig;

  duart_ctrl u_ctrl (
    .wrStrobe (wrStrobe),
    .rdStrobe (rdStrobe),
    .chanSel  (chanSel),
    .busAddr  (busAddr),
    .concWr   (afrQ[0]),
    .stat     (chanStat),
    .wrCmd    (wrCmd),
    .afrWr    (afrWr),
    .rdEn     (rdEn),
    .rdChan   (rdChan),
    .rdSel    (rdSel)
  );

  duart_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .wrCmd   (wrCmd),
    .afrWr   (afrWr),
    .wdata   (busWdata),
    .rdEn    (rdEn),
    .rdChan  (rdChan),
    .rdSel   (rdSel),
    .rxCnt   ({rxCountB, rxCountA}),
    .txCnt   ({txCountB, txCountA}),
    .op2Bit  (op2Bit),
    .baudClk (baudClk),
    .rxReady (rxReady),
    .stat    (chanStat),
    .afrQ    (afrQ),
    .mfPinN  (mfPinN),
    .rxTrig  (rxTrig),
    .txTrig  (txTrig),
    .rdata   (busRdata)
  );

  assign rxTrigA = rxTrig[0];
  assign txTrigA = txTrig[0];
  assign rxTrigB = rxTrig[1];
  assign txTrigB = txTrig[1];
endmodule

// File: rtl/duart_regfront_chk.sv
module duart_regfront_chk
  import duart_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              chanSel,
  input logic [ADDR_W-1:0] busAddr,
  input logic [REG_W-1:0]  busWdata,
  input logic              wrStrobe,
  input logic              rdStrobe,
  input logic [REG_W-1:0]  busRdata,
  input logic [AFR_W-1:0]  afrQ,
  input logic [REG_W-1:0]  lcrA,
  input logic [REG_W-1:0]  lcrB,
  input logic [NUM_CH-1:0] op2Bit,
  input logic [NUM_CH-1:0] mfPinN
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (busRdata == '0 && afrQ == '0));

  assert_solo_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && !afrQ[0] && !chanSel && busAddr == 3'd3) |=> $stable(lcrB));

  assert_conc_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && afrQ[0] && busAddr == 3'd3)
      |=> (lcrA == $past(busWdata) && lcrB == $past(busWdata)));

  assert_read_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !rdStrobe |=> $stable(busRdata));

  assert_mf_reserved_R6: assert property (@(posedge clk) disable iff (rst)
    (afrQ[2:1] == 2'b10) |-> (mfPinN == 2'b11));

  assert_mf_op2_R6: assert property (@(posedge clk) disable iff (rst)
    (afrQ[2:1] == 2'b00) |-> (mfPinN == ~op2Bit));
endmodule

bind duart_regfront duart_regfront_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .chanSel  (chanSel),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .wrStrobe (wrStrobe),
  .rdStrobe (rdStrobe),
  .busRdata (busRdata),
  .afrQ     (afrQ),
  .lcrA     (chanStat[0].lcr),
  .lcrB     (chanStat[1].lcr),
  .op2Bit   (op2Bit),
  .mfPinN   (mfPinN)
);

// File: tb/sim_duart_regfront.sv
`timescale 1ns/1ps
module sim_duart_regfront;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chanSel = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic wrStrobe = 1'b0;
  logic rdStrobe = 1'b0;
  logic [7:0] busRdata;
  logic [6:0] rxC [2];
  logic [6:0] txC [2];
  logic [1:0] op2Bit = 2'b01;
  logic [1:0] baudClk = 2'b00;
  logic [1:0] rxReady = 2'b00;
  logic [1:0] mfPinN;
  logic [7:0] rxTrigA, txTrigA, rxTrigB, txTrigB;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  duart_regfront u0 (
    .clk(clk), .rst(rst), .chanSel(chanSel), .busAddr(busAddr),
    .busWdata(busWdata), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .busRdata(busRdata), .rxCountA(rxC[0]), .txCountA(txC[0]),
    .rxCountB(rxC[1]), .txCountB(txC[1]), .op2Bit(op2Bit),
    .baudClk(baudClk), .rxReady(rxReady), .mfPinN(mfPinN),
    .rxTrigA(rxTrigA), .txTrigA(txTrigA), .rxTrigB(rxTrigB), .txTrigB(txTrigB)
  );

  // Reference model state, built from the requirements
  logic [7:0] mDat [2], mIer [2], mFifo [2], mLcr [2], mFctr [2];
  logic [7:0] mDll [2], mDlm [2], mScr [2], mRxT [2], mTxT [2];
  logic [2:0] mAfr;

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cntOf(int c);
    return mFctr[c][7] ? {1'b0, txC[c]} : {1'b0, rxC[c]};
  endfunction

  function automatic logic [7:0] expRead(int c, logic [2:0] a);
    logic dl = mLcr[c][7];
    logic z = (mDll[c] == 8'h00) && (mDlm[c] == 8'h00);
    case (a)
      3'd0: return dl ? (z ? 8'h0A : mDll[c]) : mDat[c];
      3'd1: return dl ? (z ? 8'h01 : mDlm[c]) : mIer[c];
      3'd2: return dl ? {5'b0, mAfr} : mFifo[c];
      3'd3: return mLcr[c];
      3'd4: return mFctr[c];
      3'd5: return (mLcr[c] == 8'hBF) ? cntOf(c) : 8'h00;
      3'd6: return 8'h00;
      default: return mFctr[c][6] ? cntOf(c) : mScr[c];
    endcase
  endfunction

  function automatic string tagOf(int c, logic [2:0] a);
    if (a <= 3'd1 && mLcr[c][7]) return "R7";
    if (a == 3'd2 && mLcr[c][7]) return "R5";
    if (a == 3'd5) return "R9";
    if (a == 3'd7 && mFctr[c][6]) return "R10";
    return "R11";
  endfunction

  task automatic modelWrite(int c, logic [2:0] a, logic [7:0] d);
    logic dl = mLcr[c][7];
    case (a)
      3'd0: if (dl) mDll[c] = d; else mDat[c] = d;
      3'd1: if (dl) mDlm[c] = d; else mIer[c] = d;
      3'd2: if (dl) mAfr = d[2:0]; else mFifo[c] = d;
      3'd3: mLcr[c] = d;
      3'd4: mFctr[c] = d;
      3'd5: if (mLcr[c] == 8'hBF) begin
              if (mFctr[c][7]) mTxT[c] = d; else mRxT[c] = d;
            end
      3'd7: mScr[c] = d;
      default: ;
    endcase
  endtask

  function automatic logic expMf(int c);
    case (mAfr[2:1])
      2'b00: return ~op2Bit[c];
      2'b01: return ~baudClk[c];
      2'b11: return ~rxReady[c];
      default: return 1'b1;
    endcase
  endfunction

  // One bus cycle, entered and left at a falling edge
  task automatic busOp(bit w, bit r, logic [2:0] a, logic [7:0] d, bit s, string tag);
    logic [7:0] exp;
    string t;
    bit conc;
    busAddr = a; busWdata = d; chanSel = s; wrStrobe = w; rdStrobe = r;
    exp = expRead(int'(s), a);
    t = (tag == "") ? tagOf(int'(s), a) : tag;
    conc = mAfr[0];
    if (w) for (int c = 0; c < 2; c++) if (conc || c == int'(s)) modelWrite(c, a, d);
    @(posedge clk);
    @(negedge clk);
    wrStrobe = 1'b0; rdStrobe = 1'b0;
    if (r) check8(t, busRdata, exp);
  endtask

  task automatic checkOuts();
    check8("R8 rxTrigA", rxTrigA, mRxT[0]);
    check8("R8 txTrigA", txTrigA, mTxT[0]);
    check8("R8 rxTrigB", rxTrigB, mRxT[1]);
    check8("R8 txTrigB", txTrigB, mTxT[1]);
    check8("R6 mfPinN", {6'b0, mfPinN}, {6'b0, expMf(1), expMf(0)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2752));
    for (int c = 0; c < 2; c++) begin
      rxC[c] = 7'd0; txC[c] = 7'd0;
      mDat[c] = 0; mIer[c] = 0; mFifo[c] = 0; mLcr[c] = 0; mFctr[c] = 0;
      mDll[c] = 0; mDlm[c] = 0; mScr[c] = 0; mRxT[c] = 0; mTxT[c] = 0;
    end
    mAfr = 3'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check8("R1 busRdata", busRdata, 8'h00);
    checkOuts();
    busOp(0, 1, 3'd3, 8'h00, 0, "R1");

    // R7: identification and divisor latches
    busOp(1, 0, 3'd3, 8'h80, 0, "");
    busOp(0, 1, 3'd0, 8'h00, 0, "R7");
    busOp(0, 1, 3'd1, 8'h00, 0, "R7");
    busOp(1, 0, 3'd0, 8'h05, 0, "");
    busOp(0, 1, 3'd0, 8'h00, 0, "R7");
    busOp(0, 1, 3'd1, 8'h00, 0, "R7");
    // R2: channel B untouched by solo writes to A
    busOp(0, 1, 3'd3, 8'h00, 1, "R2");
    busOp(0, 1, 3'd0, 8'h00, 1, "R2");

    // R5: shared alternate function register, reserved bits read 0
    busOp(1, 0, 3'd2, 8'hFF, 0, "");
    busOp(0, 1, 3'd2, 8'h00, 0, "R5");
    busOp(0, 1, 3'd2, 8'h00, 1, "R5");
    checkOuts();
    busOp(1, 0, 3'd3, 8'h80, 1, "");
    busOp(0, 1, 3'd2, 8'h00, 1, "R5");

    // R3: concurrent write with differing LCR bit 7 per channel
    busOp(1, 0, 3'd2, 8'h00, 0, "");
    busOp(1, 0, 3'd3, 8'h00, 1, "");
    busOp(1, 0, 3'd2, 8'h01, 0, "");
    busOp(1, 0, 3'd0, 8'h5A, 1, "");
    busOp(0, 1, 3'd0, 8'h00, 0, "R3");
    busOp(0, 1, 3'd0, 8'h00, 1, "R3");
    busOp(0, 1, 3'd1, 8'h00, 0, "R3");
    busOp(0, 1, 3'd3, 8'h00, 1, "R3");

    // R4: read and write in the same cycle return the old value
    busOp(1, 1, 3'd7, 8'h33, 1, "R4");
    busOp(0, 1, 3'd7, 8'h00, 1, "R4");
    busOp(0, 1, 3'd7, 8'h00, 0, "R4");

    // R8: trigger levels under enhanced access
    busOp(1, 0, 3'd3, 8'hBF, 0, "");
    busOp(1, 0, 3'd5, 8'h20, 0, "");
    checkOuts();
    busOp(1, 0, 3'd4, 8'h80, 0, "");
    busOp(1, 0, 3'd5, 8'h30, 1, "");
    checkOuts();
    busOp(1, 0, 3'd3, 8'h03, 0, "");
    busOp(1, 0, 3'd5, 8'h77, 0, "");
    checkOuts();
    busOp(0, 1, 3'd5, 8'h00, 0, "R9");

    // R9 / R10: FIFO count readback and scratch swap
    busOp(1, 0, 3'd3, 8'hBF, 0, "");
    rxC[0] = 7'd17; txC[0] = 7'd64; rxC[1] = 7'd3; txC[1] = 7'd40;
    busOp(0, 1, 3'd5, 8'h00, 0, "R9");
    busOp(0, 1, 3'd5, 8'h00, 1, "R9");
    busOp(1, 0, 3'd4, 8'h00, 0, "");
    busOp(0, 1, 3'd5, 8'h00, 1, "R9");
    busOp(1, 0, 3'd4, 8'h40, 0, "");
    busOp(0, 1, 3'd7, 8'h00, 0, "R10");
    busOp(1, 0, 3'd4, 8'hC0, 1, "");
    busOp(0, 1, 3'd7, 8'h00, 1, "R10");
    busOp(1, 0, 3'd4, 8'h00, 0, "");
    busOp(0, 1, 3'd7, 8'h00, 0, "R10");

    // R11: spare address and plain register map
    busOp(1, 0, 3'd3, 8'h03, 0, "");
    busOp(1, 0, 3'd6, 8'hA5, 0, "");
    busOp(0, 1, 3'd6, 8'h00, 0, "R11");
    busOp(1, 0, 3'd1, 8'h0F, 0, "");
    busOp(0, 1, 3'd1, 8'h00, 1, "R11");

    // R6: each pin function
    busOp(1, 0, 3'd3, 8'h80, 0, "");
    for (int sel = 0; sel < 4; sel++) begin
      busOp(1, 0, 3'd2, 8'(sel << 1), 0, "");
      for (int k = 0; k < 4; k++) begin
        op2Bit = 2'(k); baudClk = 2'(k + 1); rxReady = 2'(3 - k);
        #1 checkOuts();
      end
    end

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      int pick;
      pick = $urandom % 8;
      d = (pick == 0) ? 8'h00 : (pick == 1) ? 8'hBF : (pick == 2) ? 8'h80 : 8'($urandom);
      for (int c = 0; c < 2; c++) begin
        rxC[c] = 7'($urandom % 65);
        txC[c] = 7'($urandom % 65);
      end
      op2Bit = 2'($urandom); baudClk = 2'($urandom); rxReady = 2'($urandom);
      busOp(1'($urandom), 1'($urandom), 3'($urandom), d, 1'($urandom), "");
      checkOuts();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule